// File: doc/BRIEF.md
# Asynchronous Host Bus Slave Interface

This block is the slave side of a host bus. It lets a host processor reach a small internal register file through separate active-low read and write strobes. Every strobe carries exactly one data transfer. The host strobes, address, byte enables, chip select and write data arrive with no relation to the internal clock, so each one passes through a multi-stage synchronizer. The block then acts on the synchronized levels. An active-low ready output holds the host in wait states for a programmable number of internal cycles, and an active-low device-selected output reports whether the local address decoder matches.

Three ways of attaching a host are supported:
- **Address held stable.** The host keeps the address steady for the whole transfer and ties the address strobe low, which makes the address capture transparent.
- **Address latched.** The host presents the address only briefly. The block captures the address, address-enable, byte enables and chip select while the address strobe is low and holds them from its rising edge.
- **Central chip select.** A host with its own central decoder drives the chip select. This bypasses the local decoder and reaches only the data register, and only with all four byte lanes enabled.

Top module: `hbus_async_slave`

## Requirements
- R1: After reset the following hold: `host_rdy_n` is 1, `dev_sel_n` is 1, `host_rdata` is 0, and every register word reads back as 0.
- R2: While `host_ads_n` is low, the address, `host_aen`, `host_be_n` and `host_cs_n` are taken continuously. From the rising edge of `host_ads_n` the values present just before that edge are held, and later changes on those inputs have no effect until `host_ads_n` goes low again. Tying `host_ads_n` low makes the capture transparent.
- R3: `dev_sel_n` is low exactly when the captured `host_aen` is 1 and the captured address bits [15:4] equal the parameter `BASE`. The central chip select does not affect it.
- R4: A write to a selected target takes place at the rising edge of `host_wr_n`. The target is the word picked by address bits [3:2]. Only the byte lanes whose `host_be_n` bit is 0 change, where lane l is data bits [8l+7:8l]. The other lanes keep their old value.
- R5: Each low pulse of `host_wr_n` performs exactly one write. The value written is the `host_wdata` present at the last internal sample taken while the strobe was still low. Data changed during the strobe or at its rising edge is therefore handled that way: the last value before the rising edge is stored.
- R6: While `host_rd_n` is low and the target is selected, `host_rdata` follows the target word. It holds that value after `host_rd_n` rises, until the next selected read.
- R7: After a falling edge of either strobe to a selected target, `host_rdy_n` is low for exactly `cfg_wait` internal cycles (0 to 3) and then high. With `cfg_wait` = 0 it never goes low.
- R8: When the captured `host_cs_n` is 0 and all four `host_be_n` bits are 0, the access goes to the data register (word 0), whatever the address and `host_aen`.
- R9: An access that is not selected changes no register, does not change `host_rdata`, and leaves `host_rdy_n` high. An access is not selected when:
  - the central chip select is active with any `host_be_n` bit at 1, or
  - the local decoder does not match while the central chip select is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wait | input | WAIT_W (2) | Wait cycles per selected access (0 to 3) |
| host_ads_n | input | 1 | Address strobe, active low; capture holds from its rising edge |
| host_rd_n | input | 1 | Read strobe, active low |
| host_wr_n | input | 1 | Write strobe, active low |
| host_cs_n | input | 1 | Central chip select, active low |
| host_aen | input | 1 | Address enable, 1 = address valid for local decode |
| host_be_n | input | LANES (4) | Byte enables, active low, one per lane |
| host_addr | input | ADDR_W-WORD_LSB (14) | Word address, byte address bits [15:2] |
| host_wdata | input | DATA_W (32) | Write data |
| host_rdata | output | DATA_W (32) | Read data, held after the read strobe rises |
| host_rdy_n | output | 1 | Ready, active low; low inserts wait states |
| dev_sel_n | output | 1 | Local decoder match, active low |

## Verification
The checks assume that only one strobe is low at a time. They also assume that the address-side inputs and the chip select stay stable from shortly before a strobe falls until it rises, and that each strobe is held low longer than the synchronizer latency plus the largest wait count. The stimulus places every field change at least four internal cycles before a strobe edge and keeps each strobe low for ten cycles. It changes address-side inputs during a transfer only in latched-address mode, where they must be ignored. It changes write data during the strobe only in the directed case for R5.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
   localparam int LANE_W = 8;

   typedef enum logic [1:0] {
      SRC_NONE    = 2'd0,
      SRC_LOCAL   = 2'd1,
      SRC_CENTRAL = 2'd2
   } acc_src_e;
endpackage

// File: rtl/hbus_sync_pipe.sv
module hbus_sync_pipe #(
   parameter int W = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/hbus_hold_reg.sv
module hbus_hold_reg #(
   parameter int W = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= RST_VAL;
      else if (load) q <= d;
   end
endmodule

// File: rtl/hbus_wait_gen.sv
module hbus_wait_gen #(
   parameter int MAX_WAIT = 3,
   localparam int WAIT_W = $clog2(MAX_WAIT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              stop,
   input  logic [WAIT_W-1:0] cfg_wait,
   output logic              rdy_n
);
   logic [WAIT_W-1:0] cnt;
   logic [WAIT_W-1:0] load_val;

   always_comb begin
      if (int'(cfg_wait) > MAX_WAIT) load_val = WAIT_W'(MAX_WAIT);
      else                           load_val = cfg_wait;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (start)      cnt <= load_val;
      else if (stop)       cnt <= '0;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign rdy_n = (cnt == '0);
endmodule

// File: rtl/hbus_async_slave.sv
module hbus_async_slave #(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 32,
   parameter int DEC_LSB     = 4,
   parameter int BASE        = 'h030,
   parameter int MAX_WAIT    = 3,
   parameter int SYNC_STAGES = 2,
   parameter int DATA_IDX    = 0,
   localparam int LANES    = DATA_W / 8,
   localparam int WORD_LSB = $clog2(LANES),
   localparam int WAIT_W   = $clog2(MAX_WAIT + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [WAIT_W-1:0]        cfg_wait,
   input  logic                     host_ads_n,
   input  logic                     host_rd_n,
   input  logic                     host_wr_n,
   input  logic                     host_cs_n,
   input  logic                     host_aen,
   input  logic [LANES-1:0]         host_be_n,
   input  logic [ADDR_W-1:WORD_LSB] host_addr,
   input  logic [DATA_W-1:0]        host_wdata,
   output logic [DATA_W-1:0]        host_rdata,
   output logic                     host_rdy_n,
   output logic                     dev_sel_n
);
   import hbus_pkg::*;

   localparam int AW        = ADDR_W - WORD_LSB;
   localparam int MATCH_W   = ADDR_W - DEC_LSB;
   localparam int IDX_W     = DEC_LSB - WORD_LSB;
   localparam int NUM_WORDS = 2 ** IDX_W;
   localparam int FLD_W     = 2 + LANES + AW;
   localparam int SYN_W     = 3 + FLD_W + DATA_W;
   localparam logic [MATCH_W-1:0] BASE_V = MATCH_W'(BASE);
   localparam logic [FLD_W-1:0]   FLD_RST = {1'b1, 1'b0, {LANES{1'b1}}, {AW{1'b0}}};
   localparam logic [SYN_W-1:0]   SYN_RST = {3'b111, FLD_RST, {DATA_W{1'b0}}};

   if (DATA_W % LANE_W != 0) begin : g_chk_dw
      $error("DATA_W must be a whole number of byte lanes");
   end
   if (DEC_LSB <= WORD_LSB || ADDR_W <= DEC_LSB) begin : g_chk_dec
      $error("decode field must sit between word offset and address top");
   end
   if (DATA_IDX >= NUM_WORDS) begin : g_chk_idx
      $error("DATA_IDX outside the register window");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("at least two synchronizer stages are required");
   end

   // synchronize every host input together so fields stay aligned with strobes
   logic [SYN_W-1:0] s_vec;
   logic             s_ads_n, s_rd_n, s_wr_n;
   logic [FLD_W-1:0] s_fld;
   logic [DATA_W-1:0] s_wdata;

   hbus_sync_pipe #(.W(SYN_W), .STAGES(SYNC_STAGES), .RST_VAL(SYN_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({host_ads_n, host_rd_n, host_wr_n,
               host_cs_n, host_aen, host_be_n, host_addr, host_wdata}),
      .q     (s_vec)
   );

   assign {s_ads_n, s_rd_n, s_wr_n, s_fld, s_wdata} = s_vec;

   // address-side capture: transparent while the address strobe is low
   logic [FLD_W-1:0]  lat_fld;
   logic              lat_cs_n, lat_aen;
   logic [LANES-1:0]  lat_be_n;
   logic [AW-1:0]     lat_addr;

   hbus_hold_reg #(.W(FLD_W), .RST_VAL(FLD_RST)) u_fld (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (!s_ads_n),
      .d     (s_fld),
      .q     (lat_fld)
   );

   assign {lat_cs_n, lat_aen, lat_be_n, lat_addr} = lat_fld;

   // write data: last value seen while the write strobe was low
   logic [DATA_W-1:0] wd_hold;

   hbus_hold_reg #(.W(DATA_W), .RST_VAL('0)) u_wd (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (!s_wr_n),
      .d     (s_wdata),
      .q     (wd_hold)
   );

   // strobe edges from the synchronized levels
   logic rd_prev, wr_prev;
   logic rd_fall, rd_rise, wr_fall, wr_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_prev <= 1'b1;
         wr_prev <= 1'b1;
      end else begin
         rd_prev <= s_rd_n;
         wr_prev <= s_wr_n;
      end
   end

   assign rd_fall = rd_prev  & ~s_rd_n;
   assign rd_rise = ~rd_prev & s_rd_n;
   assign wr_fall = wr_prev  & ~s_wr_n;
   assign wr_rise = ~wr_prev & s_wr_n;

   // target decode
   logic             local_hit;
   logic             central_ok;
   acc_src_e         src;
   logic             sel;
   logic [IDX_W-1:0] idx;

   assign local_hit  = lat_aen && (lat_addr[AW-1:DEC_LSB-WORD_LSB] == BASE_V);
   assign central_ok = !lat_cs_n && (lat_be_n == '0);
   assign dev_sel_n  = !local_hit;

   always_comb begin
      if (!lat_cs_n) src = central_ok ? SRC_CENTRAL : SRC_NONE;
      else           src = local_hit  ? SRC_LOCAL   : SRC_NONE;
   end

   assign sel = (src != SRC_NONE);
   assign idx = (src == SRC_CENTRAL) ? IDX_W'(DATA_IDX) : lat_addr[IDX_W-1:0];

   // register file with per-lane merge
   logic                 wr_commit;
   logic [NUM_WORDS-1:0][DATA_W-1:0] rfile;
   logic [DATA_W-1:0]    rfile_nxt [NUM_WORDS];

   assign wr_commit = wr_rise && sel;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      always_comb begin
         rfile_nxt[w] = rfile[w];
         if (wr_commit && (idx == IDX_W'(w))) begin
            for (int l = 0; l < LANES; l++) begin
               if (!lat_be_n[l]) rfile_nxt[w][l*LANE_W +: LANE_W] = wd_hold[l*LANE_W +: LANE_W];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rfile <= '0;
      end else begin
         for (int w = 0; w < NUM_WORDS; w++) rfile[w] <= rfile_nxt[w];
      end
   end

   // read data follows the target while the read strobe is low, then holds
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               host_rdata <= '0;
      else if (!s_rd_n && sel)  host_rdata <= rfile[idx];
   end

   // wait-state generation
   hbus_wait_gen #(.MAX_WAIT(MAX_WAIT)) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    ((rd_fall || wr_fall) && sel),
      .stop     (rd_rise || wr_rise || !sel),
      .cfg_wait (cfg_wait),
      .rdy_n    (host_rdy_n)
   );
endmodule

// File: rtl/hbus_async_slave_chk.sv
module hbus_async_slave_chk #(
   parameter int DATA_W    = 32,
   parameter int NUM_WORDS = 4,
   parameter int LANES     = 4,
   parameter int MAX_WAIT  = 3
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             host_rdy_n,
   input logic                             s_rd_n,
   input logic [DATA_W-1:0]                host_rdata,
   input logic                             wr_commit,
   input logic                             wr_fall,
   input logic                             rd_fall,
   input logic                             sel,
   input logic                             lat_cs_n,
   input logic [LANES-1:0]                 lat_be_n,
   input logic [NUM_WORDS-1:0][DATA_W-1:0] rfile
);
   localparam int CW = $clog2(MAX_WAIT + 2) + 1;
   logic [CW-1:0] low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          low_run <= '0;
      else if (host_rdy_n) low_run <= '0;
      else                 low_run <= low_run + 1'b1;
   end

   // R7: wait states only start after a selected strobe falls
   p_wait_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(host_rdy_n) |-> $past((wr_fall || rd_fall) && sel));

   // R7: wait window never exceeds the maximum
   p_wait_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      int'(low_run) <= MAX_WAIT);

   // R5: one write per strobe
   p_single_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit |=> !wr_commit);

   // R9: register file changes only on a committed write
   p_no_stray_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_commit |=> $stable(rfile));

   // R6: read data holds while the read strobe is high
   p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(s_rd_n) |-> $stable(host_rdata));

   // R8: central select with a partial lane set never writes
   p_central_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!lat_cs_n && (lat_be_n != '0)) |-> !wr_commit);
endmodule

bind hbus_async_slave hbus_async_slave_chk #(
   .DATA_W    (DATA_W),
   .NUM_WORDS (NUM_WORDS),
   .LANES     (LANES),
   .MAX_WAIT  (MAX_WAIT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_rdy_n (host_rdy_n),
   .s_rd_n     (s_rd_n),
   .host_rdata (host_rdata),
   .wr_commit  (wr_commit),
   .wr_fall    (wr_fall),
   .rd_fall    (rd_fall),
   .sel        (sel),
   .lat_cs_n   (lat_cs_n),
   .lat_be_n   (lat_be_n),
   .rfile      (rfile)
);

// File: tb/tb_hbus_async_slave.sv
`timescale 1ns/1ps
module tb_hbus_async_slave;
   localparam int BASE = 'h030;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_wait = 2'd0;
   logic        host_ads_n = 1'b0;
   logic        host_rd_n = 1'b1;
   logic        host_wr_n = 1'b1;
   logic        host_cs_n = 1'b1;
   logic        host_aen = 1'b0;
   logic [3:0]  host_be_n = 4'hF;
   logic [15:2] host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        host_rdy_n;
   logic        dev_sel_n;

   int errors = 0;
   int checks = 0;
   logic [31:0] model [4];
   logic [31:0] last_rd;

   always #2 clk = ~clk;

   hbus_async_slave #(.BASE(BASE)) dut (
      .clk, .rst_n, .cfg_wait, .host_ads_n, .host_rd_n, .host_wr_n,
      .host_cs_n, .host_aen, .host_be_n, .host_addr, .host_wdata,
      .host_rdata, .host_rdy_n, .dev_sel_n
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit f_local(input logic aen, input logic [15:2] a);
      return aen && (a[15:4] == 12'(BASE));
   endfunction

   function automatic bit f_sel(input logic cs_n, input logic aen, input logic [3:0] be, input logic [15:2] a);
      if (!cs_n) return be == 4'h0;
      return f_local(aen, a);
   endfunction

   function automatic int f_idx(input logic cs_n, input logic [15:2] a);
      return !cs_n ? 0 : int'(a[3:2]);
   endfunction

   function automatic logic [31:0] f_merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] be);
      logic [31:0] r = old;
      for (int l = 0; l < 4; l++) if (!be[l]) r[l*8 +: 8] = nw[l*8 +: 8];
      return r;
   endfunction

   task automatic setup(input bit latched, input logic cs_n, input logic aen,
                        input logic [3:0] be, input logic [15:2] a);
      @(negedge clk);
      host_cs_n = cs_n; host_aen = aen; host_be_n = be; host_addr = a;
      if (latched) begin
         repeat (3) @(negedge clk);
         host_ads_n = 1'b1;
         repeat (4) @(negedge clk);
         // R2: scramble after the strobe rose; must be ignored
         host_cs_n = $urandom_range(1); host_aen = $urandom_range(1);
         host_be_n = 4'($urandom); host_addr = 14'($urandom);
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic finish_op();
      repeat (6) @(negedge clk);
      host_ads_n = 1'b0;
      host_cs_n = 1'b1; host_aen = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic do_write(input bit latched, input logic cs_n, input logic aen,
                           input logic [3:0] be, input logic [15:2] a,
                           input logic [31:0] d, input bit change_mid);
      bit s = f_sel(cs_n, aen, be, a);
      int lows = 0;
      setup(latched, cs_n, aen, be, a);
      host_wdata = change_mid ? ~d : d;
      host_wr_n = 1'b0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (!host_rdy_n) lows++;
         if (i == 4) begin
            chk(dev_sel_n == !f_local(aen, a), "R3 dev_sel_n on write", 32'(dev_sel_n), 32'(!f_local(aen, a)));
            if (change_mid) host_wdata = d;
         end
      end
      chk(lows == (s ? int'(cfg_wait) : 0), s ? "R7 wait count write" : "R9 no wait unselected",
          32'(lows), 32'(s ? int'(cfg_wait) : 0));
      host_wr_n = 1'b1;
      host_wdata = 32'($urandom);   // R5: change at the rising edge is not stored
      if (s) model[f_idx(cs_n, a)] = f_merge(model[f_idx(cs_n, a)], d, be);
      finish_op();
   endtask

   task automatic do_read(input bit latched, input logic cs_n, input logic aen,
                          input logic [3:0] be, input logic [15:2] a, input string tag);
      bit s = f_sel(cs_n, aen, be, a);
      int lows = 0;
      logic [31:0] exp;
      setup(latched, cs_n, aen, be, a);
      host_rd_n = 1'b0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (!host_rdy_n) lows++;
      end
      exp = s ? model[f_idx(cs_n, a)] : last_rd;
      chk(host_rdata == exp, tag, host_rdata, exp);
      chk(lows == (s ? int'(cfg_wait) : 0), "R7 wait count read", 32'(lows), 32'(s ? int'(cfg_wait) : 0));
      host_rd_n = 1'b1;
      last_rd = exp;
      finish_op();
      chk(host_rdata == exp, "R6 rdata held after strobe", host_rdata, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [15:2] base_a;
      void'($urandom(32'h5eed_0042));
      for (int w = 0; w < 4; w++) model[w] = '0;
      last_rd = '0;
      base_a = {12'(BASE), 2'b00};
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(host_rdy_n == 1'b1, "R1 ready idle", 32'(host_rdy_n), 32'd1);
      chk(dev_sel_n == 1'b1, "R1 dev_sel idle", 32'(dev_sel_n), 32'd1);
      chk(host_rdata == '0, "R1 rdata reset", host_rdata, 32'd0);
      for (int w = 0; w < 4; w++) do_read(0, 1'b1, 1'b1, 4'h0, base_a | 14'(w), "R1 word reset value");

      cfg_wait = 2'd2;
      do_write(0, 1'b1, 1'b1, 4'h0, base_a | 14'd1, 32'hA1B2_C3D4, 0);
      do_read(0, 1'b1, 1'b1, 4'h0, base_a | 14'd1, "R4 full write readback");
      do_write(0, 1'b1, 1'b1, 4'b1010, base_a | 14'd1, 32'h1122_3344, 0);
      do_read(0, 1'b1, 1'b1, 4'h0, base_a | 14'd1, "R4 lane merge readback");
      cfg_wait = 2'd3;
      do_write(1, 1'b1, 1'b1, 4'h0, base_a | 14'd2, 32'h0BAD_F00D, 0);
      do_read(1, 1'b1, 1'b1, 4'h0, base_a | 14'd2, "R2 latched address readback");
      cfg_wait = 2'd0;
      do_write(0, 1'b1, 1'b1, 4'h0, base_a | 14'd3, 32'hCAFE_0001, 1);
      do_read(0, 1'b1, 1'b1, 4'h0, base_a | 14'd3, "R5 last value stored");
      cfg_wait = 2'd1;
      do_write(0, 1'b0, 1'b0, 4'h0, 14'h2A5B, 32'h5A5A_A5A5, 0);
      do_read(0, 1'b1, 1'b1, 4'h0, base_a, "R8 central write lands in data reg");
      do_write(0, 1'b0, 1'b1, 4'b0011, base_a | 14'd2, 32'hFFFF_FFFF, 0);
      do_read(0, 1'b1, 1'b1, 4'h0, base_a | 14'd2, "R8 partial central ignored");
      do_write(0, 1'b1, 1'b0, 4'h0, base_a | 14'd1, 32'hDEAD_BEEF, 0);
      do_write(0, 1'b1, 1'b1, 4'h0, 14'h0101, 32'hDEAD_BEEF, 0);
      do_read(0, 1'b1, 1'b1, 4'h0, 14'h0101, "R9 unselected read keeps rdata");
      do_read(0, 1'b1, 1'b1, 4'h0, base_a | 14'd1, "R9 unselected write changed nothing");
      do_read(0, 1'b0, 1'b0, 4'h0, 14'h1234, "R8 central read of data reg");

      for (int n = 0; n < 60; n++) begin
         logic [15:2] a;
         logic        cs, aen;
         logic [3:0]  be;
         bit          lat = $urandom_range(1);
         cfg_wait = 2'($urandom);
         a   = ($urandom_range(3) != 0) ? (base_a | 14'($urandom_range(3))) : 14'($urandom);
         aen = ($urandom_range(5) != 0);
         cs  = ($urandom_range(4) != 0);
         be  = ($urandom_range(2) == 0) ? 4'h0 : 4'($urandom);
         if ($urandom_range(1)) do_write(lat, cs, aen, be, a, 32'($urandom), 0);
         else                   do_read(lat, cs, aen, be, a, "R6 random read");
      end
      for (int w = 0; w < 4; w++) do_read(0, 1'b1, 1'b1, 4'h0, base_a | 14'(w), "R4 final contents");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule